// File: doc/BRIEF.md
# Per-Probe Programmable Trigger Unit

This block watches a set of probe inputs, each with its own bit width, and raises a single trigger when any probe meets its programmed condition. Each probe has two configuration registers. One holds a 4-bit operation code. The other holds a comparison constant as wide as the probe. Software or a sequencer writes these registers through a one-cycle write port, so the trigger condition can change at runtime.

Two kinds of operation exist. Edge-type operations compare the current sample of a probe with its sample from the previous clock cycle. Compare-type operations compare the current sample with the stored constant. Every comparison is unsigned. Each probe produces its own hit result, and the hits are OR-combined and registered. A downstream capture controller can therefore use the trigger as a clean, registered start signal.

The block uses no sequencing state machine. Each lane holds only its configuration and a one-sample history. The output register is the single point where the lanes meet.

Top module: `probe_trigger_unit`

## Requirements
- R1: While reset is held, and after it is released, `trig_o` is 0 and every probe's operation is DISABLED. No probe activity raises the trigger until a configuration is written.
- R2: Operation code 0 (DISABLED) never fires. The unused codes 10 to 15 never fire either.
- R3: Code 1 (RISING) fires when the probe's current unsigned value is greater than its value on the previous cycle.
- R4: Code 2 (FALLING) fires when the probe's current unsigned value is less than its value on the previous cycle.
- R5: Code 3 (CHANGING) fires when the probe's current value differs from its value on the previous cycle.
- R6: These codes fire when the probe, compared against its constant as an unsigned number, meets the test:
  - code 4: greater than
  - code 5: less than
  - code 6: greater than or equal
  - code 7: less than or equal
- R7: Code 8 fires when the probe equals its constant. Code 9 fires when it does not.
- R8: `trig_o` is the OR of all probe hits. A hit on any one enabled probe raises it, whatever the other probes do.
- R9: `trig_o` is registered. The sample present at clock edge t, compared against the sample present at edge t-1, sets `trig_o` right after edge t.
- R10: Register writes:
  - A write with `cfg_we`=1 targets probe `cfg_addr[2:1]`, which is the probe index.
  - `cfg_addr[0]`=0 selects the operation register, loaded from `cfg_wdata[3:0]`.
  - `cfg_addr[0]`=1 selects the constant register.
  - A written value governs the sample at the next edge after the write edge.
  - Writes to a probe index of 3 or more change nothing.
- R11: The constant register of a probe keeps only the low probe-width bits of `cfg_wdata`. Higher bits are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| probes_i | input | 13 | Packed probes: probe 0 in bit 0 (1 bit), probe 1 in bits 3:1 (3 bits), probe 2 in bits 12:4 (9 bits) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | {probe index[1:0], field select}; field 0 = operation, 1 = constant |
| cfg_wdata | input | 9 | Write data; operation in bits 3:0, constant in the low probe-width bits |
| trig_o | output | 1 | Registered combined trigger |

## Verification
Every operation code from 0 to 15 is tried on the 3-bit probe. The sweep covers every constant and every ordered pair of previous and current values, so it separates strict from non-strict compares and increase from decrease at each boundary. The 1-bit probe gets the same full sweep.

The 9-bit probe is driven across its extremes and the 255/256 carry boundary. This shows that the compares are unsigned and span the full width. Mixed patterns across probes show the OR merge.

Writes carrying high garbage bits check truncation. Writes to an absent index must change no behaviour. A sample taken before the clock edge confirms the one-cycle latency.

// File: rtl/trig_pkg.sv
package trig_pkg;

    localparam int MAX_LANES = 16;
    localparam int OPW       = 4;

    typedef int wlist_t [MAX_LANES];

    typedef enum logic [OPW-1:0] {
        OP_OFF  = 4'd0,
        OP_RISE = 4'd1,
        OP_FALL = 4'd2,
        OP_CHG  = 4'd3,
        OP_GT   = 4'd4,
        OP_LT   = 4'd5,
        OP_GE   = 4'd6,
        OP_LE   = 4'd7,
        OP_EQ   = 4'd8,
        OP_NE   = 4'd9
    } trig_op_e;

    // bit offset of lane idx inside a packed bus of lanes
    function automatic int w_off(wlist_t w, int idx);
        int s;
        s = 0;
        for (int j = 0; j < MAX_LANES; j++) begin
            if (j < idx) s += w[j];
        end
        return s;
    endfunction

    function automatic int w_max(wlist_t w, int n);
        int m;
        m = 1;
        for (int j = 0; j < MAX_LANES; j++) begin
            if (j < n && w[j] > m) m = w[j];
        end
        return m;
    endfunction

endpackage

// File: rtl/trig_eval.sv
module trig_eval
    import trig_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [OPW-1:0] op,
    input  logic [W-1:0]   cur,
    input  logic [W-1:0]   prev,
    input  logic [W-1:0]   arg,
    output logic           hit
);

    logic gt_p, lt_p, gt_a, lt_a, eq_a;

    always_comb begin
        gt_p = (cur > prev);
        lt_p = (cur < prev);
        gt_a = (cur > arg);
        lt_a = (cur < arg);
        eq_a = (cur == arg);
    end

    always_comb begin
        case (op)
            OP_RISE: hit = gt_p;
            OP_FALL: hit = lt_p;
            OP_CHG:  hit = gt_p | lt_p;
            OP_GT:   hit = gt_a;
            OP_LT:   hit = lt_a;
            OP_GE:   hit = gt_a | eq_a;
            OP_LE:   hit = lt_a | eq_a;
            OP_EQ:   hit = eq_a;
            OP_NE:   hit = ~eq_a;
            default: hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/trig_lane.sv
module trig_lane
    import trig_pkg::*;
#(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [W-1:0]   probe,
    input  logic [OPW-1:0] op,
    input  logic [W-1:0]   arg,
    output logic           hit
);

    logic [W-1:0] prev_q;

    // history register: follows the probe every cycle
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= probe;
    end

    trig_eval #(.W(W)) u_eval (
        .op   (op),
        .cur  (probe),
        .prev (prev_q),
        .arg  (arg),
        .hit  (hit)
    );

    a_r2_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 4'd0 || op > 4'd9) |-> !hit);

    a_r3_rise_means_up: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 4'd1 && hit) |-> (probe > $past(probe)));

    a_r4_fall_means_down: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 4'd2 && hit) |-> (probe < $past(probe)));

    a_r5_change_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 4'd3) |-> (hit == (probe != $past(probe))));

endmodule

// File: rtl/trig_cfg_regs.sv
module trig_cfg_regs
    import trig_pkg::*;
#(
    parameter int     NPROBE  = 3,
    parameter wlist_t PROBE_W = '{0: 1, 1: 3, 2: 9, default: 0},
    parameter int     DW      = 9,
    parameter int     IDXW    = 2
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  we,
    input  logic [IDXW:0]                         addr,
    input  logic [DW-1:0]                         wdata,
    output logic [NPROBE*OPW-1:0]                 ops_o,
    output logic [w_off(PROBE_W, NPROBE)-1:0]     args_o
);

    logic [IDXW-1:0] idx;
    logic            sel_arg;

    assign idx     = addr[IDXW:1];
    assign sel_arg = addr[0];

    for (genvar g = 0; g < NPROBE; g++) begin : g_lane
        localparam int              W    = PROBE_W[g];
        localparam int              OFF  = w_off(PROBE_W, g);
        localparam logic [IDXW-1:0] MINE = IDXW'(g);

        logic [OPW-1:0] op_r;
        logic [W-1:0]   arg_r;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                op_r  <= '0;
                arg_r <= '0;
            end else if (we && idx == MINE) begin
                if (sel_arg) arg_r <= wdata[W-1:0];
                else         op_r  <= wdata[OPW-1:0];
            end
        end

        assign ops_o[g*OPW +: OPW] = op_r;
        assign args_o[OFF +: W]    = arg_r;

        a_r10_op_loads: assert property (@(posedge clk) disable iff (!rst_n)
            (we && !sel_arg && idx == MINE) |=> (op_r == $past(wdata[OPW-1:0])));

        a_r11_arg_loads: assert property (@(posedge clk) disable iff (!rst_n)
            (we && sel_arg && idx == MINE) |=> (arg_r == $past(wdata[W-1:0])));
    end

    a_r10_bad_index: assert property (@(posedge clk) disable iff (!rst_n)
        (we && int'(idx) >= NPROBE) |=> ($stable(ops_o) && $stable(args_o)));

endmodule

// File: rtl/probe_trigger_unit.sv
module probe_trigger_unit
    import trig_pkg::*;
#(
    parameter int     NPROBE  = 3,
    parameter wlist_t PROBE_W = '{0: 1, 1: 3, 2: 9, default: 0},
    localparam int    PTOT    = w_off(PROBE_W, NPROBE),
    localparam int    MAXW    = w_max(PROBE_W, NPROBE),
    localparam int    DW      = (MAXW > OPW) ? MAXW : OPW,
    localparam int    IDXW    = (NPROBE > 1) ? $clog2(NPROBE) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PTOT-1:0] probes_i,
    input  logic            cfg_we,
    input  logic [IDXW:0]   cfg_addr,
    input  logic [DW-1:0]   cfg_wdata,
    output logic            trig_o
);

    logic [NPROBE*OPW-1:0] ops;
    logic [PTOT-1:0]       args;
    logic [NPROBE-1:0]     hits;
    logic                  trig_q;
    logic                  any_armed;

    trig_cfg_regs #(
        .NPROBE  (NPROBE),
        .PROBE_W (PROBE_W),
        .DW      (DW),
        .IDXW    (IDXW)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .addr   (cfg_addr),
        .wdata  (cfg_wdata),
        .ops_o  (ops),
        .args_o (args)
    );

    for (genvar g = 0; g < NPROBE; g++) begin : g_lane
        localparam int W   = PROBE_W[g];
        localparam int OFF = w_off(PROBE_W, g);

        trig_lane #(.W(W)) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .probe (probes_i[OFF +: W]),
            .op    (ops[g*OPW +: OPW]),
            .arg   (args[OFF +: W]),
            .hit   (hits[g])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) trig_q <= 1'b0;
        else        trig_q <= |hits;
    end

    assign trig_o = trig_q;

    always_comb begin
        any_armed = 1'b0;
        for (int i = 0; i < NPROBE; i++) begin
            if (ops[i*OPW +: OPW] != 4'd0 && ops[i*OPW +: OPW] <= 4'd9) any_armed = 1'b1;
        end
    end

    a_r2_idle_no_trigger: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(any_armed) |-> !trig_o);

    a_r8_any_hit_fires: assert property (@(posedge clk) disable iff (!rst_n)
        (hits != '0) |=> trig_o);

endmodule

// File: tb/probe_trigger_unit_test.sv
`timescale 1ns/1ps
module probe_trigger_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] probes_i = '0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [8:0]  cfg_wdata = '0;
    logic        trig_o;

    int checks = 0;
    int errors = 0;
    int cur [3];
    int last [3];
    int bop [3];
    int barg [3];
    int pw [3] = '{1, 3, 9};
    int v2 [6] = '{0, 1, 255, 256, 510, 511};

    always #10 clk = ~clk;

    probe_trigger_unit uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .probes_i  (probes_i),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .trig_o    (trig_o)
    );

    function automatic int model(int op, int a, int c, int p);
        case (op)
            1: return int'(c > p);
            2: return int'(c < p);
            3: return int'(c != p);
            4: return int'(c > a);
            5: return int'(c < a);
            6: return int'(c >= a);
            7: return int'(c <= a);
            8: return int'(c == a);
            9: return int'(c != a);
            default: return 0;
        endcase
    endfunction

    function automatic string tag_of(int op);
        if (op == 1) return "R3";
        if (op == 2) return "R4";
        if (op == 3) return "R5";
        if (op >= 4 && op <= 7) return "R6";
        if (op == 8 || op == 9) return "R7";
        return "R2";
    endfunction

    task automatic check(string tag, int expv);
        checks++;
        if (trig_o !== 1'(expv)) begin
            errors++;
            $display("FAIL %s trig_o=%0b expected=%0d at %0t", tag, trig_o, expv, $time);
        end
    endtask

    task automatic put(int a, int b, int c);
        cur[0] = a & 1;
        cur[1] = b & 7;
        cur[2] = c & 511;
        probes_i = {9'(cur[2]), 3'(cur[1]), 1'(cur[0])};
    endtask

    task automatic tick(string tag);
        int e;
        e = 0;
        for (int i = 0; i < 3; i++) begin
            if (model(bop[i], barg[i], cur[i], last[i]) != 0) e = 1;
        end
        @(negedge clk);
        check(tag, e);
        for (int i = 0; i < 3; i++) last[i] = cur[i];
    endtask

    task automatic write_cfg(int idx, int sel, int data, string tag);
        cfg_we    = 1'b1;
        cfg_addr  = {2'(idx), 1'(sel)};
        cfg_wdata = 9'(data);
        tick(tag);
        cfg_we = 1'b0;
        if (idx < 3) begin
            if (sel == 0) bop[idx] = data & 15;
            else          barg[idx] = data & ((1 << pw[idx]) - 1);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 3; i++) begin
            cur[i] = 0; last[i] = 0; bop[i] = 0; barg[i] = 0;
        end
        repeat (3) @(negedge clk);
        check("R1", 0);
        rst_n = 1'b1;

        // R1: no configuration yet, activity must not trigger
        put(1, 7, 511); tick("R1");
        put(0, 0, 0);   tick("R1");
        put(1, 3, 256); tick("R1");

        // full sweep on the 3-bit probe: all codes, constants and value pairs
        for (int op = 0; op < 16; op++) begin
            for (int a = 0; a < 8; a++) begin
                write_cfg(1, 0, op, tag_of(op));
                write_cfg(1, 1, a, tag_of(op));
                for (int p = 0; p < 8; p++) begin
                    for (int c = 0; c < 8; c++) begin
                        put(0, p, 0); tick(tag_of(op));
                        put(0, c, 0); tick(tag_of(op));
                    end
                end
            end
        end
        write_cfg(1, 0, 0, "R2");

        // full sweep on the 1-bit probe
        for (int op = 0; op < 16; op++) begin
            for (int a = 0; a < 2; a++) begin
                write_cfg(0, 0, op, tag_of(op));
                write_cfg(0, 1, a, tag_of(op));
                for (int p = 0; p < 2; p++) begin
                    for (int c = 0; c < 2; c++) begin
                        put(p, 0, 0); tick(tag_of(op));
                        put(c, 0, 0); tick(tag_of(op));
                    end
                end
            end
        end
        write_cfg(0, 0, 0, "R2");

        // 9-bit probe at extremes and the carry boundary
        for (int op = 1; op < 10; op++) begin
            for (int ai = 0; ai < 3; ai++) begin
                write_cfg(2, 0, op, tag_of(op));
                write_cfg(2, 1, (ai == 0) ? 0 : ((ai == 1) ? 256 : 511), tag_of(op));
                for (int p = 0; p < 6; p++) begin
                    for (int c = 0; c < 6; c++) begin
                        put(0, 0, v2[p]); tick(tag_of(op));
                        put(0, 0, v2[c]); tick(tag_of(op));
                    end
                end
            end
        end

        // R8: OR of lane 0 RISING and lane 2 EQ 300
        write_cfg(0, 0, 1, "R8");
        write_cfg(2, 0, 8, "R8");
        write_cfg(2, 1, 300, "R8");
        put(0, 2, 0);   tick("R8");
        put(1, 2, 0);   tick("R8");
        put(1, 5, 300); tick("R8");
        put(0, 5, 300); tick("R8");
        put(0, 5, 5);   tick("R8");
        put(1, 5, 300); tick("R8");
        put(1, 0, 299); tick("R8");
        write_cfg(0, 0, 0, "R8");
        write_cfg(2, 0, 0, "R8");

        // R11: high data bits dropped for the 3-bit constant
        write_cfg(1, 0, 8, "R11");
        write_cfg(1, 1, 9'h1F5, "R11");
        put(0, 5, 0); tick("R11");
        put(0, 4, 0); tick("R11");
        put(0, 5, 0); tick("R11");

        // R9: output changes only after the edge
        put(0, 4, 0); tick("R9");
        put(0, 5, 0);
        #2;
        check("R9", 0);
        tick("R9");

        // R10: absent index ignored, op field uses low 4 bits
        write_cfg(3, 0, 3, "R10");
        write_cfg(3, 1, 0, "R10");
        put(0, 5, 0); tick("R10");
        put(0, 2, 0); tick("R10");
        put(0, 5, 0); tick("R10");
        write_cfg(1, 0, 9'h1F3, "R10");
        put(0, 5, 0); tick("R10");
        put(0, 6, 0); tick("R10");
        put(0, 6, 0); tick("R10");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule